// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit timer-counter that runs from a machine-cycle clock enable. It either counts every enabled cycle (timer function) or counts high-to-low transitions seen on an external count pin (counter function). A second external pin, the trigger, works with a 16-bit capture/reload register. Software can also write this register. The block offers three behaviours.

- **Capture:** the counter free-runs and wraps from the top of its range to zero. A trigger falling edge snapshots the live count into the register.
- **Auto-reload up:** the counter restarts from the register value at the top of its range, or when a trigger edge arrives.
- **Auto-reload up/down:** the trigger pin level chooses the counting direction. Reaching the register value while counting down is an underflow, which reloads all ones. The external flag acts as a toggling seventeenth count bit.

The block keeps two sticky flags, overflow and external. Software clears each flag with a one-cycle strobe. A hardware set always wins over a clear in the same cycle. Both pins are sampled only in enabled cycles. An edge is a sample of 1 followed by a sample of 0 in the next enabled cycle.

Top module: `tmr_capreload`

## Requirements
- R1: With `run`=1 and `ctr_sel`=0, `count` rises by one in each clock cycle where `tick`=1. When `tick`=0 or `run`=0, `count` holds.
- R2: With `ctr_sel`=1, `count` rises by one only in a `tick` cycle whose `cnt_pin` sample is 0 while the sample from the previous `tick` cycle was 1. A pin held at one level never counts.
- R3: In capture behaviour (`reload_mode`=0), an increment from 0xFFFF gives 0x0000 and sets `ovf_flag`.
- R4: In capture behaviour with `ext_en`=1, a trigger falling edge copies the pre-increment `count` into `rld` and sets `ext_flag`. The edge rule is the same as in R2, applied to `trig_pin`. With `ext_en`=0 such an edge changes neither `rld` nor `ext_flag`.
- R5: With `reload_mode`=1 and `dn_en`=0, an increment from 0xFFFF loads `rld` into `count` and sets `ovf_flag`. In this case the `trig_pin` level does not change the direction.
- R6: With `reload_mode`=1, `dn_en`=0 and `ext_en`=1, a trigger falling edge loads `rld` into `count` and sets `ext_flag`, even when `run`=0.
- R7: With `reload_mode`=1 and `dn_en`=1, a `trig_pin` level of 1 counts up and a level of 0 counts down. A down step taken while `count` equals `rld` loads 0xFFFF and sets `ovf_flag`. An up step from 0xFFFF loads `rld` and sets `ovf_flag`.
- R8: In up/down behaviour, `ext_flag` inverts on every overflow and underflow. Trigger falling edges neither reload nor capture.
- R9: `rld_we` writes `rld_wdata` into `rld`. `ovf_clr` and `ext_clr` clear their flags. On a same-cycle collision, the capture wins over the write and a flag set wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Machine-cycle enable |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External trigger / direction pin |
| run | input | 1 | Counting enable |
| ctr_sel | input | 1 | 0 timer, 1 counter function |
| ext_en | input | 1 | Enables trigger edge actions |
| dn_en | input | 1 | Enables up/down behaviour in reload mode |
| reload_mode | input | 1 | 0 capture, 1 auto-reload |
| rld_we | input | 1 | Software write strobe for the register |
| rld_wdata | input | 16 | Software write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external flag |
| count | output | 16 | Live count |
| rld | output | 16 | Capture/reload register |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External flag |

## Verification
The hardest state to reach is the counter near its limits with a known register value, because the count itself has no write port. The stimulus first writes a chosen register value, such as 0xFFFA or 0x12. It then forces a reload with a trigger falling edge while the block is stopped, so the counter sits a few steps away from overflow or underflow. The bench then switches behaviour or direction and counts across the boundary. It also times the clear and write strobes to land exactly on the overflow step and on the capture step, which exercises the collision priorities.

// File: rtl/tmr_pkg.sv
// Shared types for the capture/reload timer.
// Assumes: behaviour is decoded once at the top and fanned out.
package tmr_pkg;
    typedef enum logic [1:0] {
        BEH_CAPTURE = 2'd0,
        BEH_RLD_UP  = 2'd1,
        BEH_RLD_UPDN = 2'd2
    } tmr_beh_e;

    // Decodes the mode inputs into one behaviour.
    function automatic tmr_beh_e decode_beh(input logic reload_mode, input logic dn_en);
        if (!reload_mode) return BEH_CAPTURE;
        else if (dn_en)   return BEH_RLD_UPDN;
        else              return BEH_RLD_UP;
    endfunction
endpackage

// File: rtl/tmr_fall_detect.sv
// Samples a set of pins once per machine cycle and flags a high-then-low pair.
// Assumes: pins are already synchronous to clk; the sample history resets low.
module tmr_fall_detect #(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NPINS-1:0] pins,
    output logic [NPINS-1:0] fall
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic last_q;

        // Keeps the sample taken in the previous enabled cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)    last_q <= 1'b0;
            else if (tick) last_q <= pins[g];
        end

        // An edge is a previous sample of 1 with a present sample of 0.
        assign fall[g] = tick & last_q & ~pins[g];
    end
endmodule

// File: rtl/tmr_count_core.sv
// Holds the live count and the overflow/underflow events.
// Assumes: force_rld is already qualified by behaviour, ext_en and the edge.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         ctr_sel,
    input  logic         cnt_fall,
    input  logic         trig_lvl,
    input  tmr_beh_e     beh,
    input  logic         force_rld,
    input  logic [W-1:0] rld_val,
    output logic [W-1:0] count,
    output logic         over_evt,
    output logic         under_evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         step;
    logic         going_down;
    logic [W-1:0] count_n;

    // Decides whether this cycle advances the count, and in which direction.
    always_comb begin
        step       = run & tick & (ctr_sel ? cnt_fall : 1'b1);
        going_down = (beh == BEH_RLD_UPDN) & ~trig_lvl;
        over_evt   = step & ~going_down & (count == TOP);
        under_evt  = step & going_down & (count == rld_val);
    end

    // Picks the next count: an edge reload first, then the boundaries, then a step.
    always_comb begin
        count_n = count;
        if (force_rld)      count_n = rld_val;
        else if (over_evt)  count_n = (beh == BEH_CAPTURE) ? '0 : rld_val;
        else if (under_evt) count_n = TOP;
        else if (step)      count_n = going_down ? count - 1'b1 : count + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_n;
    end
endmodule

// File: rtl/tmr_cap_reg.sv
// Capture/reload register, written by software or loaded by a capture.
// Assumes: a capture and a software write in one cycle resolve to the capture.
module tmr_cap_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] cap_val,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    // Register update, with the capture taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (cap) value <= cap_val;
        else if (we)  value <= wdata;
    end
endmodule

// File: rtl/tmr_flags.sv
// Sticky overflow and external flags with software clear.
// Assumes: any hardware set or toggle beats a clear in the same cycle.
module tmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic ovf_clr,
    input  logic ext_set,
    input  logic ext_tgl,
    input  logic ext_clr,
    output logic ovf_flag,
    output logic ext_flag
);
    // Overflow flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    // External flag: toggle, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_flag <= 1'b0;
        else if (ext_tgl) ext_flag <= ~ext_flag;
        else if (ext_set) ext_flag <= 1'b1;
        else if (ext_clr) ext_flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_capreload.sv
// Top of the 16-bit capture/reload timer-counter.
// Assumes: tick marks machine cycles; inputs are synchronous to clk.
module tmr_capreload
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_pin,
    input  logic         trig_pin,
    input  logic         run,
    input  logic         ctr_sel,
    input  logic         ext_en,
    input  logic         dn_en,
    input  logic         reload_mode,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] rld,
    output logic         ovf_flag,
    output logic         ext_flag
);
    localparam int CNT_IDX  = 0;
    localparam int TRIG_IDX = 1;

    tmr_beh_e   beh;
    logic [1:0] falls;
    logic       do_cap;
    logic       do_rld;
    logic       over_evt;
    logic       under_evt;

    // Behaviour decode and qualification of the trigger edge.
    always_comb begin
        beh    = decode_beh(reload_mode, dn_en);
        do_cap = (beh == BEH_CAPTURE) & ext_en & falls[TRIG_IDX];
        do_rld = (beh == BEH_RLD_UP)  & ext_en & falls[TRIG_IDX];
    end

    tmr_fall_detect #(.NPINS(2)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pins  ({trig_pin, cnt_pin}),
        .fall  (falls)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .ctr_sel   (ctr_sel),
        .cnt_fall  (falls[CNT_IDX]),
        .trig_lvl  (trig_pin),
        .beh       (beh),
        .force_rld (do_rld),
        .rld_val   (rld),
        .count     (count),
        .over_evt  (over_evt),
        .under_evt (under_evt)
    );

    tmr_cap_reg #(.W(W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (do_cap),
        .cap_val (count),
        .we      (rld_we),
        .wdata   (rld_wdata),
        .value   (rld)
    );

    tmr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_set  (over_evt | under_evt),
        .ovf_clr  (ovf_clr),
        .ext_set  (do_cap | do_rld),
        .ext_tgl  ((beh == BEH_RLD_UPDN) & (over_evt | under_evt)),
        .ext_clr  (ext_clr),
        .ovf_flag (ovf_flag),
        .ext_flag (ext_flag)
    );
endmodule

// File: rtl/tmr_capreload_chk.sv
// Checker bound to the timer top; observes ports only.
// Assumes: synchronous active-low reset.
module tmr_capreload_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         run,
    input logic         ctr_sel,
    input logic         trig_pin,
    input logic         ext_en,
    input logic         dn_en,
    input logic         reload_mode,
    input logic         rld_we,
    input logic         ovf_clr,
    input logic [W-1:0] count,
    input logic [W-1:0] rld,
    input logic         ovf_flag,
    input logic         ext_flag
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // R1: without an enabled cycle the count never moves.
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R3: wrap to zero in capture behaviour.
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_mode && run && tick && !ctr_sel && count == TOP) |=> (count == '0 && ovf_flag));

    // R4/R9: the register changes only through a write or an enabled capture.
    assert_rld_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_we && !(ext_en && !reload_mode)) |=> $stable(rld));

    // R7: underflow reloads all ones and flags.
    assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_mode && dn_en && !trig_pin && run && tick && !ctr_sel && count == rld)
        |=> (count == TOP && ovf_flag));

    // R8: the external flag inverts on an underflow.
    assert_ext_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_mode && dn_en && !trig_pin && run && tick && !ctr_sel && count == rld)
        |=> (ext_flag != $past(ext_flag)));

    // R9: the overflow flag is sticky until cleared.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind tmr_capreload tmr_capreload_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (run),
    .ctr_sel     (ctr_sel),
    .trig_pin    (trig_pin),
    .ext_en      (ext_en),
    .dn_en       (dn_en),
    .reload_mode (reload_mode),
    .rld_we      (rld_we),
    .ovf_clr     (ovf_clr),
    .count       (count),
    .rld         (rld),
    .ovf_flag    (ovf_flag),
    .ext_flag    (ext_flag)
);

// File: tb/sim_tmr_capreload.sv
module sim_tmr_capreload;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0, run = 1'b0;
    logic        ctr_sel = 1'b0, ext_en = 1'b0, dn_en = 1'b0, reload_mode = 1'b0;
    logic        rld_we = 1'b0, ovf_clr = 1'b0, ext_clr = 1'b0;
    logic [15:0] rld_wdata = '0;
    logic [15:0] count, rld;
    logic        ovf_flag, ext_flag;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tmr_capreload u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .run(run), .ctr_sel(ctr_sel), .ext_en(ext_en), .dn_en(dn_en),
        .reload_mode(reload_mode), .rld_we(rld_we), .rld_wdata(rld_wdata),
        .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count(count), .rld(rld),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset count", count, 16'h0);
        chk("R9 reset rld", rld, 16'h0);
        chk("R9 reset ovf", {15'd0, ovf_flag}, 16'd0);
        chk("R9 reset ext", {15'd0, ext_flag}, 16'd0);
    endtask

    task automatic t_timer();
        run = 1; tick = 1; step(10);
        chk("R1 ten ticks", count, 16'd10);
        for (int i = 0; i < 9; i++) begin
            tick = (i % 3 == 0); step(1);
        end
        chk("R1 gated ticks", count, 16'd13);
        tick = 1; run = 0; step(5);
        chk("R1 run low holds", count, 16'd13);
    endtask

    task automatic t_counter();
        logic [15:0] c0;
        ctr_sel = 1; run = 1; cnt_pin = 0; step(2);
        c0 = count;
        for (int i = 0; i < 5; i++) begin
            cnt_pin = 1; step(1); cnt_pin = 0; step(1);
        end
        chk("R2 five pulses", count, c0 + 16'd5);
        cnt_pin = 1; step(4); cnt_pin = 0; step(4);
        chk("R2 slow pulse counts once", count, c0 + 16'd6);
        ctr_sel = 0; run = 0;
    endtask

    task automatic t_reload_edge();
        reload_mode = 1; dn_en = 0; ext_en = 1;
        rld_we = 1; rld_wdata = 16'hFFFA; step(1); rld_we = 0;
        chk("R9 sw write", rld, 16'hFFFA);
        trig_pin = 1; step(1); trig_pin = 0; step(1);
        chk("R6 edge reload", count, 16'hFFFA);
        chk("R6 ext set", {15'd0, ext_flag}, 16'd1);
        ext_clr = 1; step(1); ext_clr = 0;
        chk("R9 ext clear", {15'd0, ext_flag}, 16'd0);
    endtask

    task automatic t_reload_up();
        run = 1; step(5);
        chk("R5 up with trig low", count, 16'hFFFF);
        chk("R5 no flag yet", {15'd0, ovf_flag}, 16'd0);
        step(1);
        chk("R5 overflow reload", count, 16'hFFFA);
        chk("R5 ovf set", {15'd0, ovf_flag}, 16'd1);
        ovf_clr = 1; step(1); ovf_clr = 0;
        chk("R9 ovf clear", {15'd0, ovf_flag}, 16'd0);
        step(4);
        ovf_clr = 1; step(1); ovf_clr = 0;
        chk("R9 set beats clear", {15'd0, ovf_flag}, 16'd1);
        chk("R5 second reload", count, 16'hFFFA);
    endtask

    task automatic t_capture_wrap();
        reload_mode = 0; ovf_clr = 1; step(1); ovf_clr = 0;
        chk("R3 flag cleared", {15'd0, ovf_flag}, 16'd0);
        step(4);
        chk("R3 at top", count, 16'hFFFF);
        step(1);
        chk("R3 wrap to zero", count, 16'h0000);
        chk("R3 ovf set", {15'd0, ovf_flag}, 16'd1);
    endtask

    task automatic t_capture();
        logic [15:0] x, y;
        ext_en = 1; trig_pin = 1; step(1);
        x = count;
        trig_pin = 0; step(1);
        chk("R4 captured value", rld, x);
        chk("R4 count continues", count, x + 16'd1);
        chk("R4 ext set", {15'd0, ext_flag}, 16'd1);
        ext_clr = 1; step(1); ext_clr = 0;
        ext_en = 0; trig_pin = 1; step(1); trig_pin = 0; step(1);
        chk("R4 disabled no capture", rld, x);
        chk("R4 disabled no flag", {15'd0, ext_flag}, 16'd0);
        ext_en = 1; trig_pin = 1; step(1);
        y = count;
        trig_pin = 0; rld_we = 1; rld_wdata = 16'h1234; step(1); rld_we = 0;
        chk("R9 capture beats write", rld, y);
        rld_we = 1; step(1); rld_we = 0;
        chk("R9 plain write", rld, 16'h1234);
        run = 0;
    endtask

    task automatic t_updown();
        reload_mode = 1; dn_en = 0; ext_en = 1;
        rld_we = 1; rld_wdata = 16'h0012; step(1); rld_we = 0;
        trig_pin = 1; step(1); trig_pin = 0; step(1);
        rld_we = 1; rld_wdata = 16'h0010; step(1); rld_we = 0;
        ovf_clr = 1; ext_clr = 1; step(1); ovf_clr = 0; ext_clr = 0;
        chk("R7 preload", count, 16'h0012);
        dn_en = 1; run = 1; step(2);
        chk("R7 counts down", count, 16'h0010);
        step(1);
        chk("R7 underflow loads top", count, 16'hFFFF);
        chk("R7 ovf on underflow", {15'd0, ovf_flag}, 16'd1);
        chk("R8 ext toggled on", {15'd0, ext_flag}, 16'd1);
        trig_pin = 1; step(1);
        chk("R7 up overflow reload", count, 16'h0010);
        chk("R8 ext toggled off", {15'd0, ext_flag}, 16'd0);
        step(2);
        chk("R7 counts up", count, 16'h0012);
        run = 0; trig_pin = 0; step(1);
        chk("R8 edge no reload", count, 16'h0012);
        chk("R8 edge no flag", {15'd0, ext_flag}, 16'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_timer();
        t_counter();
        t_reload_edge();
        t_reload_up();
        t_capture_wrap();
        t_capture();
        t_updown();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule